// File: doc/BRIEF.md
# Host-to-DSP Mailbox Interface

This block sits between a host processor's 16-bit register bus and a DSP. Through a data port the host reads and writes words of DSP data memory at an address pointer. The pointer can step forward by itself after every access. Reads are only accepted inside a read burst, and a burst is either 1, 8 or 16 words long or open-ended. The host starts and cancels a burst through a configuration register. The same register holds the DSP in reset and selects the memory region that transfers go to. Only region 0, DSP data memory, is accepted.

Three command channels carry one word each from host to DSP, and three reply channels carry one word each back. A command stays pending until the DSP acknowledges it. A reply stays ready until the host reads it. A 16-bit semaphore with set, clear and mask registers gives a shared flag word. A status register gives the burst state, the semaphore flag and the per-channel pending and ready flags at a glance.

On the DSP side the block presents a plain synchronous memory port, with a combinational read word, plus per-channel command words, pending flags, acknowledge inputs and reply push strobes. Host read data is combinational from the current state, and the side effects of a read (burst count, pointer step, ready clear) take place at the clock edge that ends the access.

Top module: `dsp_mailbox`

## Requirements
- R1: Byte offset 0x00 is the data port. A write stores the host word to DSP memory at the pointer. An accepted read returns the DSP memory word at the pointer in the same cycle.
- R2: A write to offset 0x04 loads the 16-bit pointer, and a read of 0x04 returns it.
- R3: When config bit 1 is set, every accepted data-port access advances the pointer by one. An access at pointer 0xFFFF wraps it to 0x0000 and raises `xfer_err` during that access.
- R4: Config bits [3:2] give the burst length: code 0 is 1 word, 1 is 8, 2 is 16, and 3 is unlimited. After the last counted read, status bits 0 and 6 drop. In unlimited mode they stay set.
- R5: A config write with bit 4 set starts a burst and sets status bits 0 (reading) and 6 (data available). A config write with bit 4 clear cancels any burst and clears both bits.
- R6: When config bits [15:12] are non-zero, a data-port access is rejected: no memory write, read data 0, the pointer unchanged, the burst count unchanged, and `xfer_err` high during the access.
- R7: A data-port read with no burst active is rejected in the same way as in R6.
- R8: A config write that sets bit 0 while it was clear raises `dsp_reset`. A config write that clears bit 0 while it was set drops `dsp_reset` and clears the semaphore, the mask, the burst and all channel flags, so that status reads 0x0100.
- R9: Writes to 0x20, 0x28 and 0x30 place the word on `cmd_word` for channels 0, 1 and 2 and set that channel's `cmd_pending`. A set `cmd_ack` bit clears it. A second write while pending replaces the word.
- R10: A `rep_push` bit latches that channel's `rep_data` word and sets its ready flag. Reads of 0x24, 0x2C and 0x34 return the channel 0, 1 and 2 word and clear the flag.
- R11: A write to 0x10 ORs bits into the semaphore and a write to 0x18 clears them. 0x14 holds the mask and reads back. Reads of 0x10 and 0x1C return the semaphore. Status bit 9 is set when any semaphore bit is set whose mask bit is clear.
- R12: Status at 0x0C is {pending[2:0], ready[2:0], semaphore flag, 1, 0, reading, 00000, reading}, with bit 15 the channel 2 pending flag. After reset it reads 0x0100, config reads 0, and unassigned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 6 | Register byte offset |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word, combinational |
| xfer_err | output | 1 | Data-port access rejected or pointer wrapped |
| dsp_reset | output | 1 | Hold the DSP in reset |
| dsp_mem_addr | output | 16 | DSP data memory address (the pointer) |
| dsp_mem_wr | output | 1 | DSP data memory write enable |
| dsp_mem_wdata | output | 16 | DSP data memory write word |
| dsp_mem_rdata | input | 16 | DSP data memory read word at `dsp_mem_addr` |
| cmd_word | output | 48 | Command words, channel n at bits [16n+15:16n] |
| cmd_pending | output | 3 | Per-channel command not yet acknowledged |
| cmd_ack | input | 3 | Per-channel command acknowledge from the DSP |
| rep_data | input | 48 | Reply words, channel n at bits [16n+15:16n] |
| rep_push | input | 3 | Per-channel reply push strobe |

## Verification
The bench aims at the end of each burst length, with reads counted to exactly 1, 8 and 16. A counter that is off by one would leave the reading flag set one read too long, or drop it one read early. It drives the pointer through 0xFFFF with auto-increment on. A design that saturates, or that fails to flag the wrap, shows a wrong pointer readback or a missing `xfer_err`. Data accesses with a non-zero region, and reads outside a burst, are checked afterwards through memory readback and the pointer. A design that lets them through corrupts memory or moves the pointer. A reset release with the semaphore, the mask and the channel flags all set has to give a status of 0x0100. Randomly mixed register and DSP-side traffic checks the semaphore masking and the channel overwrite and clear rules.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W    = 16;
  localparam int CH_N      = 3;
  localparam int OFS_W     = 6;
  localparam int CH_STRIDE = 8;

  localparam logic [OFS_W-1:0] OFS_DATA = 6'h00;
  localparam logic [OFS_W-1:0] OFS_PTR  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CFG  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_SSET = 6'h10;
  localparam logic [OFS_W-1:0] OFS_SMSK = 6'h14;
  localparam logic [OFS_W-1:0] OFS_SCLR = 6'h18;
  localparam logic [OFS_W-1:0] OFS_SVAL = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_CMD0 = 6'h20;
  localparam logic [OFS_W-1:0] OFS_REP0 = 6'h24;

  localparam int CFG_RST = 0;
  localparam int CFG_INC = 1;
  localparam int CFG_LEN = 2;
  localparam int CFG_GO  = 4;
  localparam int CFG_RGN = 12;

  // words in a burst for a length code; 0 stands for open-ended
  function automatic logic [4:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd8;
      2'd2:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic busy, input logic sem_flag,
                                                    input logic [CH_N-1:0] rdy,
                                                    input logic [CH_N-1:0] pend);
    return {pend, rdy, sem_flag, 1'b1, 1'b0, busy, 5'b00000, busy};
  endfunction
endpackage

// File: rtl/mbx_xfer.sv
module mbx_xfer import mbx_pkg::*; #(
  parameter int PTR_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_ld,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             cfg_wr,
  input  logic             go,
  input  logic [1:0]       len_code,
  input  logic             region_ok,
  input  logic             autoinc,
  input  logic             acc_rd,
  input  logic             acc_wr,
  output logic [PTR_W-1:0] ptr_q,
  output logic             busy,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             wrap_ev,
  output logic             rej_ev
);
  logic [CNT_W-1:0] left_q;
  logic             unl_q;
  logic             step;

  assign rd_ok   = acc_rd && region_ok && busy;
  assign wr_ok   = acc_wr && region_ok;
  assign step    = (rd_ok || wr_ok) && autoinc;
  assign wrap_ev = step && (ptr_q == '1);
  assign rej_ev  = (acc_rd || acc_wr) && !(rd_ok || wr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ld) begin
      ptr_q <= ptr_val;
    end else if (step) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
      unl_q  <= 1'b0;
    end else if (cfg_wr) begin
      busy   <= go;
      left_q <= go ? CNT_W'(burst_words(len_code)) : '0;
      unl_q  <= go && (len_code == 2'd3);
    end else if (rd_ok && !unl_q) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_sema.sv
module mbx_sema #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] sem_q,
  output logic [SW-1:0] mask_q,
  output logic          flag
);
  assign flag = |(sem_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem_q  <= '0;
      mask_q <= '0;
    end else if (clr) begin
      sem_q  <= '0;
      mask_q <= '0;
    end else begin
      if (set_we)       sem_q <= sem_q | wdata;
      else if (clr_we)  sem_q <= sem_q & ~wdata;
      if (mask_we)      mask_q <= wdata;
    end
  end
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rel,
  input  logic         cmd_we,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  input  logic         push,
  input  logic [W-1:0] rep_in,
  input  logic         rep_rd,
  output logic [W-1:0] cmd_q,
  output logic         pend_q,
  output logic [W-1:0] rep_q,
  output logic         rdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      pend_q <= 1'b0;
      rep_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= wdata;
      if (push)   rep_q <= rep_in;
      if (rel)         pend_q <= 1'b0;
      else if (cmd_we) pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
      if (rel)         rdy_q <= 1'b0;
      else if (push)   rdy_q <= 1'b1;
      else if (rep_rd) rdy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dsp_mailbox.sv
module dsp_mailbox import mbx_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [OFS_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  output logic                   xfer_err,
  output logic                   dsp_reset,
  output logic [DATA_W-1:0]      dsp_mem_addr,
  output logic                   dsp_mem_wr,
  output logic [DATA_W-1:0]      dsp_mem_wdata,
  input  logic [DATA_W-1:0]      dsp_mem_rdata,
  output logic [CH_N*DATA_W-1:0] cmd_word,
  output logic [CH_N-1:0]        cmd_pending,
  input  logic [CH_N-1:0]        cmd_ack,
  input  logic [CH_N*DATA_W-1:0] rep_data,
  input  logic [CH_N-1:0]        rep_push
);
  logic [DATA_W-1:0] cfg_q;
  logic              cfg_wr, rise_ev, fall_ev;
  logic [DATA_W-1:0] ptr_q, sem_q, mask_q, st_word;
  logic              busy, rd_ok, wr_ok, wrap_ev, rej_ev, sem_flag;
  logic [CH_N-1:0]   rdy_v;
  logic [DATA_W-1:0] rep_w [CH_N];

  assign cfg_wr  = host_wr && (host_addr == OFS_CFG);
  assign rise_ev = cfg_wr && host_wdata[CFG_RST] && !cfg_q[CFG_RST];
  assign fall_ev = cfg_wr && !host_wdata[CFG_RST] && cfg_q[CFG_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      dsp_reset <= 1'b0;
    end else begin
      if (cfg_wr)  cfg_q <= host_wdata;
      if (rise_ev) dsp_reset <= 1'b1;
      else if (fall_ev) dsp_reset <= 1'b0;
    end
  end

  mbx_xfer #(.PTR_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .ptr_ld(host_wr && (host_addr == OFS_PTR)), .ptr_val(host_wdata),
    .cfg_wr(cfg_wr), .go(host_wdata[CFG_GO]), .len_code(host_wdata[CFG_LEN +: 2]),
    .region_ok(cfg_q[CFG_RGN +: 4] == 4'd0), .autoinc(cfg_q[CFG_INC]),
    .acc_rd(host_rd && (host_addr == OFS_DATA)), .acc_wr(host_wr && (host_addr == OFS_DATA)),
    .ptr_q(ptr_q), .busy(busy), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .wrap_ev(wrap_ev), .rej_ev(rej_ev)
  );

  mbx_sema #(.SW(DATA_W)) u_sema (
    .clk(clk), .rst_n(rst_n), .clr(fall_ev),
    .set_we(host_wr && (host_addr == OFS_SSET)),
    .clr_we(host_wr && (host_addr == OFS_SCLR)),
    .mask_we(host_wr && (host_addr == OFS_SMSK)),
    .wdata(host_wdata), .sem_q(sem_q), .mask_q(mask_q), .flag(sem_flag)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    localparam logic [OFS_W-1:0] CMD_A = OFS_W'(int'(OFS_CMD0) + CH_STRIDE * g);
    localparam logic [OFS_W-1:0] REP_A = OFS_W'(int'(OFS_REP0) + CH_STRIDE * g);
    mbx_chan #(.W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .rel(fall_ev),
      .cmd_we(host_wr && (host_addr == CMD_A)), .wdata(host_wdata),
      .ack(cmd_ack[g]), .push(rep_push[g]), .rep_in(rep_data[g*DATA_W +: DATA_W]),
      .rep_rd(host_rd && (host_addr == REP_A)),
      .cmd_q(cmd_word[g*DATA_W +: DATA_W]), .pend_q(cmd_pending[g]),
      .rep_q(rep_w[g]), .rdy_q(rdy_v[g])
    );
  end

  assign st_word       = DATA_W'(pack_status(busy, sem_flag, rdy_v, cmd_pending));
  assign xfer_err      = wrap_ev || rej_ev;
  assign dsp_mem_addr  = ptr_q;
  assign dsp_mem_wr    = wr_ok;
  assign dsp_mem_wdata = host_wdata;

  always_comb begin
    case (host_addr)
      OFS_DATA:           host_rdata = rd_ok ? dsp_mem_rdata : '0;
      OFS_PTR:            host_rdata = ptr_q;
      OFS_CFG:            host_rdata = cfg_q;
      OFS_STAT:           host_rdata = st_word;
      OFS_SSET, OFS_SVAL: host_rdata = sem_q;
      OFS_SMSK:           host_rdata = mask_q;
      default:            host_rdata = '0;
    endcase
    for (int i = 0; i < CH_N; i++) begin
      if (host_addr == OFS_W'(int'(OFS_REP0) + CH_STRIDE * i)) host_rdata = rep_w[i];
    end
  end
endmodule

module mbx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [5:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic        dsp_reset,
  input logic [2:0]  cmd_pending,
  input logic        xfer_err,
  input logic        dsp_mem_wr,
  input logic [15:0] st_word,
  input logic [15:0] sem_q,
  input logic [15:0] ptr_q,
  input logic [15:0] cfg_q,
  input logic        wrap_ev,
  input logic [2:0]  rep_push
);
  // R9
  cmd0_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h20) |=> cmd_pending[0]);
  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h08 && host_wdata[0]) |=> dsp_reset);
  // R8
  rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h08 && !host_wdata[0] && dsp_reset) |=> (sem_q == 16'd0 && !dsp_reset));
  // R5
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h08 && !host_wdata[4]) |=> (!st_word[0] && !st_word[6]));
  // R11
  sem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == 16'd0) |-> !st_word[9]);
  // R6
  region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h00 && cfg_q[15:12] != 4'd0) |-> (!dsp_mem_wr && xfer_err));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (ptr_q == 16'd0));
  // R10
  rep_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push[0] |=> st_word[10]);
endmodule

bind dsp_mailbox mbx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .dsp_reset(dsp_reset), .cmd_pending(cmd_pending),
  .xfer_err(xfer_err), .dsp_mem_wr(dsp_mem_wr), .st_word(st_word), .sem_q(sem_q),
  .ptr_q(ptr_q), .cfg_q(cfg_q), .wrap_ev(wrap_ev), .rep_push(rep_push)
);

// File: tb/test_dsp_mailbox.sv
module test_dsp_mailbox;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        xfer_err, dsp_reset, mem_wr;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [47:0] cmd_word;
  logic [2:0]  cmd_pending;
  logic [2:0]  cmd_ack = '0, rep_push = '0;
  logic [47:0] rep_data = '0;

  always #(CLK_NS/2) clk = ~clk;

  dsp_mailbox i_dsp_mailbox (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_err(xfer_err), .dsp_reset(dsp_reset),
    .dsp_mem_addr(mem_addr), .dsp_mem_wr(mem_wr), .dsp_mem_wdata(mem_wdata),
    .dsp_mem_rdata(mem_rdata), .cmd_word(cmd_word), .cmd_pending(cmd_pending),
    .cmd_ack(cmd_ack), .rep_data(rep_data), .rep_push(rep_push)
  );

  // DSP data memory stand-in
  logic [15:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  // bench model
  logic [15:0] m_mem [256];
  logic [15:0] m_ptr, m_cfg, m_sem, m_mask;
  logic [15:0] m_cmd [3];
  logic [15:0] m_rep [3];
  logic [2:0]  m_pend, m_rdy;
  logic        m_busy, m_unl, m_rst;
  int          m_left;
  int total = 0, bad = 0;

  function automatic int f_len(input logic [1:0] c);
    if (c == 2'd0) return 1;
    if (c == 2'd1) return 8;
    if (c == 2'd2) return 16;
    return 0;
  endfunction

  function automatic logic [15:0] f_stat();
    logic [15:0] s;
    s = 16'h0100;
    s[0] = m_busy;
    s[6] = m_busy;
    s[9] = (m_sem & ~m_mask) != 16'd0;
    s[12:10] = m_rdy;
    s[15:13] = m_pend;
    return s;
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00: return "R1";
      6'h04: return "R2";
      6'h08: return "R5";
      6'h0C: return "R12";
      6'h10, 6'h14, 6'h18, 6'h1C: return "R11";
      6'h20, 6'h28, 6'h30: return "R9";
      6'h24, 6'h2C, 6'h34: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic side_chk();
    chk("R8", {15'd0, dsp_reset}, {15'd0, m_rst});
    chk("R9", {13'd0, cmd_pending}, {13'd0, m_pend});
    for (int i = 0; i < 3; i++) chk("R9", cmd_word[i*16 +: 16], m_cmd[i]);
  endtask

  task automatic host(input bit wr, input logic [5:0] a, input logic [15:0] d, input string tag);
    logic [15:0] er;
    logic        ee;
    bit          ok;
    er = 16'd0;
    ee = 1'b0;
    if (a == 6'h00) begin
      ok = (m_cfg[15:12] == 4'd0) && (wr || m_busy);
      ee = !ok || (m_cfg[1] && m_ptr == 16'hFFFF);
      if (ok) begin
        if (wr) m_mem[m_ptr[7:0]] = d;
        else begin
          er = m_mem[m_ptr[7:0]];
          if (!m_unl) begin
            m_left--;
            if (m_left == 0) m_busy = 1'b0;
          end
        end
        if (m_cfg[1]) m_ptr = m_ptr + 16'd1;
      end
    end else if (wr) begin
      case (a)
        6'h04: m_ptr = d;
        6'h08: begin
          if (m_cfg[0] && !d[0]) begin
            m_sem = 0; m_mask = 0; m_pend = 0; m_rdy = 0;
          end
          m_rst = d[0];
          m_cfg = d;
          m_busy = d[4];
          m_left = d[4] ? f_len(d[3:2]) : 0;
          m_unl = d[4] && d[3:2] == 2'd3;
        end
        6'h10: m_sem = m_sem | d;
        6'h14: m_mask = d;
        6'h18: m_sem = m_sem & ~d;
        6'h20, 6'h28, 6'h30: begin
          m_cmd[(a - 6'h20) / 8] = d;
          m_pend[(a - 6'h20) / 8] = 1'b1;
        end
        default: ;
      endcase
    end else begin
      case (a)
        6'h04: er = m_ptr;
        6'h08: er = m_cfg;
        6'h0C: er = f_stat();
        6'h10, 6'h1C: er = m_sem;
        6'h14: er = m_mask;
        6'h24, 6'h2C, 6'h34: begin
          er = m_rep[(a - 6'h24) / 8];
          m_rdy[(a - 6'h24) / 8] = 1'b0;
        end
        default: er = 16'd0;
      endcase
    end
    @(negedge clk);
    host_wr = wr; host_rd = !wr; host_addr = a; host_wdata = d;
    #1;
    if (!wr) chk(tag, host_rdata, er);
    chk(tag, {15'd0, xfer_err}, {15'd0, ee});
    @(posedge clk);
    #1;
    host_wr = 1'b0; host_rd = 1'b0;
    side_chk();
  endtask

  task automatic dsp(input logic [2:0] ack, input logic [2:0] push, input logic [15:0] base);
    @(negedge clk);
    cmd_ack = ack; rep_push = push;
    rep_data = {base + 16'd2, base + 16'd1, base};
    @(posedge clk);
    #1;
    cmd_ack = 0; rep_push = 0;
    m_pend = m_pend & ~ack;
    for (int i = 0; i < 3; i++) if (push[i]) begin
      m_rdy[i] = 1'b1;
      m_rep[i] = base + 16'(i);
    end
    side_chk();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0]  ra;
    logic [15:0] rd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 16'(i * 16'h0101) ^ 16'h5A5A;
      m_mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
    end
    m_ptr = 0; m_cfg = 0; m_sem = 0; m_mask = 0; m_pend = 0; m_rdy = 0;
    m_busy = 0; m_unl = 0; m_rst = 0; m_left = 0;
    for (int i = 0; i < 3; i++) begin m_cmd[i] = 0; m_rep[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    host(0, 6'h0C, 0, "R12");
    host(0, 6'h08, 0, "R12");
    host(0, 6'h3C, 0, "R12");
    // R2 pointer load, R1 write then single-word burst read
    host(1, 6'h04, 16'h0010, "R2");
    host(0, 6'h04, 0, "R2");
    host(1, 6'h00, 16'hBEEF, "R1");
    host(1, 6'h08, 16'h0010, "R5");
    host(0, 6'h0C, 0, "R5");
    host(0, 6'h00, 0, "R1");
    host(0, 6'h0C, 0, "R4");
    // R7 read outside burst
    host(0, 6'h00, 0, "R7");
    host(0, 6'h04, 0, "R7");
    // R3 wrap
    host(1, 6'h08, 16'h0002, "R3");
    host(1, 6'h04, 16'hFFFE, "R3");
    host(1, 6'h00, 16'h1111, "R3");
    host(1, 6'h00, 16'h2222, "R3");
    host(0, 6'h04, 0, "R3");
    // R4 burst lengths
    host(1, 6'h04, 16'h0020, "R4");
    host(1, 6'h08, 16'h0016, "R4");
    for (int i = 0; i < 7; i++) host(0, 6'h00, 0, "R4");
    host(0, 6'h0C, 0, "R4");
    host(0, 6'h00, 0, "R4");
    host(0, 6'h0C, 0, "R4");
    host(1, 6'h08, 16'h001A, "R4");
    for (int i = 0; i < 15; i++) host(0, 6'h00, 0, "R4");
    host(0, 6'h0C, 0, "R4");
    host(0, 6'h00, 0, "R4");
    host(0, 6'h0C, 0, "R4");
    host(1, 6'h08, 16'h001E, "R4");
    for (int i = 0; i < 20; i++) host(0, 6'h00, 0, "R4");
    host(0, 6'h0C, 0, "R4");
    // R5 cancel
    host(1, 6'h08, 16'h0002, "R5");
    host(0, 6'h0C, 0, "R5");
    host(0, 6'h00, 0, "R5");
    // R6 region rejection
    host(1, 6'h04, 16'h0040, "R6");
    host(1, 6'h08, 16'h3012, "R6");
    host(1, 6'h00, 16'hDEAD, "R6");
    host(0, 6'h00, 0, "R6");
    host(0, 6'h04, 0, "R6");
    host(1, 6'h08, 16'h0010, "R6");
    host(0, 6'h00, 0, "R6");
    // R11 semaphore
    host(1, 6'h10, 16'h00F0, "R11");
    host(1, 6'h10, 16'h0003, "R11");
    host(0, 6'h1C, 0, "R11");
    host(1, 6'h14, 16'h00F3, "R11");
    host(0, 6'h0C, 0, "R11");
    host(1, 6'h14, 16'h00F1, "R11");
    host(0, 6'h0C, 0, "R11");
    host(1, 6'h18, 16'h00F3, "R11");
    host(0, 6'h10, 0, "R11");
    host(0, 6'h14, 0, "R11");
    // R9 commands
    host(1, 6'h20, 16'hA000, "R9");
    host(1, 6'h28, 16'hA001, "R9");
    host(1, 6'h20, 16'hA0FF, "R9");
    host(0, 6'h0C, 0, "R9");
    dsp(3'b001, 3'b000, 0);
    host(0, 6'h0C, 0, "R9");
    // R10 replies
    dsp(3'b000, 3'b101, 16'h7000);
    host(0, 6'h0C, 0, "R10");
    host(0, 6'h34, 0, "R10");
    host(0, 6'h0C, 0, "R10");
    host(0, 6'h24, 0, "R10");
    // R8 reset hold and release
    host(1, 6'h10, 16'h0101, "R8");
    host(1, 6'h14, 16'h0100, "R8");
    host(1, 6'h30, 16'hC3C3, "R8");
    dsp(3'b000, 3'b010, 16'h0300);
    host(1, 6'h08, 16'h0011, "R8");
    host(0, 6'h0C, 0, "R8");
    host(1, 6'h08, 16'h0000, "R8");
    host(0, 6'h0C, 0, "R8");
    host(0, 6'h1C, 0, "R8");
    host(0, 6'h14, 0, "R8");

    // mixed random traffic
    for (int n = 0; n < 2500; n++) begin
      int k;
      k = int'($urandom % 16);
      rd = 16'($urandom);
      if (k < 3) begin
        dsp(3'($urandom), 3'($urandom), rd);
      end else if (k == 3) begin
        rd[15:12] = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
        rd[0] = ($urandom % 8 == 0);
        host(1, 6'h08, rd, "R5");
      end else if (k == 4) begin
        if ($urandom % 3 == 0) rd = 16'hFFF0 | 16'($urandom % 16);
        host(1, 6'h04, rd, "R2");
      end else begin
        case ($urandom % 12)
          0: ra = 6'h00; 1: ra = 6'h0C; 2: ra = 6'h10; 3: ra = 6'h14;
          4: ra = 6'h18; 5: ra = 6'h1C; 6: ra = 6'h20; 7: ra = 6'h28;
          8: ra = 6'h30; 9: ra = 6'h24; 10: ra = 6'h2C; default: ra = 6'h34;
        endcase
        host(bit'($urandom % 2), ra, rd, tag_of(ra));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule